// File: doc/BRIEF.md
# Indirect Command Bridge to a Local Peripheral Bus

This block lets software on a 64-bit register window run single accesses on a 32-bit local peripheral bus. The window decodes four doubleword registers: control, reset, status and data. Writing the control register starts a command. The control word carries the direction, the access size in bytes and a 32-bit bus address. A write command sends the word held in the data register. A read command returns its data through the status register.

Software starts a command and then polls the status register until the done flag (bit 11) appears. The status register is cleared when a command launches, and a read of it returns its value and clears it in the same access. A read that the bus answers with an error still completes, but it reports all ones in the data field. Only one command is in flight at a time, and a control write that arrives while a command is in progress is dropped.

The sequencer has three states. ST_IDLE waits for a control write and moves to ST_ISSUE when one arrives. ST_ISSUE holds the bus request until it is accepted and then moves to ST_WAIT. ST_WAIT waits for the bus response, records the result in status and returns to ST_IDLE.

Top module: `cmd_window_bridge`

## Requirements
- R1: The register is selected by window address bits 4:3 (address >> 3 modulo 4): 0 control, 1 reset, 2 status, 3 data. All other address bits are ignored.
- R2: A write to the data register stores win_wdata[63:32]. A read of it returns the stored word in bits 63:32 with zeros in bits 31:0. It resets to zero.
- R3: Reads of the control and reset registers return zero. Writes to the status register and to the reset register change no state and start no bus request.
- R4: A control write in ST_IDLE raises exactly one bus request, with lb_req_write = NOT bit 48, lb_req_size = bits 59:56 and lb_req_addr = bits 31:0. The request and its fields are held stable until lb_req_ready.
- R5: A write command drives the data register value on lb_req_wdata (byte at bits 31:24 first). On its response, status becomes 64'h800 (done flag only), whether or not the bus reports an error.
- R6: A read command that completes without error sets status to 64'h800 OR (lb_rsp_rdata << 26), which places the data in bits 57:26.
- R7: A read command that completes with lb_rsp_err set sets status to 64'h800 OR (32'hFFFFFFFF << 26).
- R8: A status read returns the current value and clears it to zero. Status is cleared at launch, so it reads zero while a command is in progress.
- R9: A control write that arrives outside ST_IDLE is dropped. It causes no extra bus request and does not change the request in flight.
- R10: After reset, status, data and the readable registers are zero and no bus request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_wr | input | 1 | Window write strobe, one cycle per access |
| win_rd | input | 1 | Window read strobe, one cycle per access |
| win_addr | input | WIN_AW | Window byte address |
| win_wdata | input | 64 | Window write data |
| win_rdata | output | 64 | Window read data, valid in the cycle of win_rd |
| lb_req_valid | output | 1 | Bus request valid |
| lb_req_ready | input | 1 | Bus request accepted |
| lb_req_write | output | 1 | 1 = write, 0 = read |
| lb_req_size | output | 4 | Access size in bytes |
| lb_req_addr | output | 32 | Bus address |
| lb_req_wdata | output | 32 | Write data, most significant byte first |
| lb_rsp_valid | input | 1 | Bus response valid |
| lb_rsp_err | input | 1 | Bus response error |
| lb_rsp_rdata | input | 32 | Bus read data, first byte in bits 31:24 |

## Verification
A table of commands walks the bridge through writes and reads of several sizes and addresses. Some read back words written earlier, so a wrong field position or byte order in the status capture shows up. Error responses go to both a read and a write, which separates the all-ones substitution on reads from the done-only result on writes. An all-ones data word is read back so that its result can be compared with the error pattern. Directed tests stall the bus acceptance to hold a command in flight, to show that a second control write is dropped and that status reads zero until completion. Separate tests cover aliased window addresses and writes to the status and reset registers.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
    localparam int WORD_W        = 64;
    localparam int LB_W          = 32;
    localparam int SZ_W          = 4;
    localparam int CTL_RD_BIT    = 48;
    localparam int CTL_SZ_LSB    = 56;
    localparam int STAT_DONE_BIT = 11;
    localparam int STAT_RD_LSB   = 26;
    localparam int DATA_LSB      = WORD_W - LB_W;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_RST  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_DATA = 2'd3
    } win_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic            is_read;
        logic [SZ_W-1:0] size;
        logic [LB_W-1:0] addr;
        logic [LB_W-1:0] wdata;
    } cmd_t;
endpackage

// File: rtl/cwb_regfile.sv
module cwb_regfile
    import cwb_pkg::*;
#(
    parameter int WIN_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_wr,
    input  logic              win_rd,
    input  logic [WIN_AW-1:0] win_addr,
    input  logic [WORD_W-1:0] win_wdata,
    output logic [WORD_W-1:0] win_rdata,
    output logic              cmd_go,
    output cmd_t              cmd,
    input  logic              launch,
    input  logic              cap_valid,
    input  logic              cap_read,
    input  logic              cap_err,
    input  logic [LB_W-1:0]   cap_rdata
);
    localparam int SEL_LSB = 3;

    win_sel_e          sel;
    logic [LB_W-1:0]   data_q;
    logic [WORD_W-1:0] status_q;
    logic [WORD_W-1:0] cap_word;
    logic [LB_W-1:0]   cap_field;
    logic              unused_addr;

    assign sel         = win_sel_e'(win_addr[SEL_LSB+1:SEL_LSB]);
    assign unused_addr = ^{win_addr[WIN_AW-1:SEL_LSB+2], win_addr[SEL_LSB-1:0]};

    // command decode from a control write
    assign cmd_go        = win_wr && (sel == SEL_CTRL);
    assign cmd.is_read   = win_wdata[CTL_RD_BIT];
    assign cmd.size      = win_wdata[CTL_SZ_LSB +: SZ_W];
    assign cmd.addr      = win_wdata[LB_W-1:0];
    assign cmd.wdata     = data_q;

    // result word composed from the sequencer's capture
    always_comb begin
        cap_field = '0;
        if (cap_read) cap_field = cap_err ? '1 : cap_rdata;
        cap_word                = '0;
        cap_word[STAT_RD_LSB +: LB_W] = cap_field;
        cap_word[STAT_DONE_BIT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (win_wr && (sel == SEL_DATA)) begin
            data_q <= win_wdata[WORD_W-1:DATA_LSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (cap_valid) begin
            status_q <= cap_word;
        end else if (launch) begin
            status_q <= '0;
        end else if (win_rd && (sel == SEL_STAT)) begin
            status_q <= '0;
        end
    end

    always_comb begin
        win_rdata = '0;
        if (win_rd) begin
            unique case (sel)
                SEL_CTRL: win_rdata = '0;
                SEL_RST:  win_rdata = '0;
                SEL_STAT: win_rdata = status_q;
                SEL_DATA: win_rdata = {data_q, {DATA_LSB{1'b0}}};
            endcase
        end
    end

    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> status_q[STAT_DONE_BIT]); // R5

    AST_STATUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd && (sel == SEL_STAT) && !cap_valid) |=> (status_q == '0)); // R8

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_wr) |=> $stable(data_q)); // R3
endmodule

// File: rtl/cwb_seq.sv
module cwb_seq
    import cwb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_go,
    input  cmd_t            cmd,
    output logic            launch,
    output logic            cap_valid,
    output logic            cap_read,
    output logic            cap_err,
    output logic [LB_W-1:0] cap_rdata,
    output logic            lb_req_valid,
    input  logic            lb_req_ready,
    output logic            lb_req_write,
    output logic [SZ_W-1:0] lb_req_size,
    output logic [LB_W-1:0] lb_req_addr,
    output logic [LB_W-1:0] lb_req_wdata,
    input  logic            lb_rsp_valid,
    input  logic            lb_rsp_err,
    input  logic [LB_W-1:0] lb_rsp_rdata
);
    seq_state_e state, nxt;
    cmd_t       cur_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (cmd_go)       nxt = ST_ISSUE;
            ST_ISSUE: if (lb_req_ready) nxt = ST_WAIT;
            ST_WAIT:  if (lb_rsp_valid) nxt = ST_IDLE;
            default:                    nxt = ST_IDLE;
        endcase
    end

    // command held for the duration of the transaction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cur_q <= '0;
        else if (launch) cur_q <= cmd;
    end

    // outputs
    always_comb begin
        launch       = 1'b0;
        cap_valid    = 1'b0;
        lb_req_valid = 1'b0;
        unique case (state)
            ST_IDLE:  launch       = cmd_go;
            ST_ISSUE: lb_req_valid = 1'b1;
            ST_WAIT:  cap_valid    = lb_rsp_valid;
            default:  ;
        endcase
        cap_read     = cur_q.is_read;
        cap_err      = lb_rsp_err;
        cap_rdata    = lb_rsp_rdata;
        lb_req_write = !cur_q.is_read;
        lb_req_size  = cur_q.size;
        lb_req_addr  = cur_q.addr;
        lb_req_wdata = cur_q.wdata;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_req_valid && !lb_req_ready) |=> (lb_req_valid && $stable(lb_req_addr)
                                            && $stable(lb_req_write))); // R4

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && cmd_go) |=> $stable(lb_req_addr)); // R9

    AST_NO_REQ_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_req_valid && lb_req_ready) |=> !lb_req_valid); // R4
endmodule

// File: rtl/cmd_window_bridge.sv
module cmd_window_bridge
    import cwb_pkg::*;
#(
    parameter int WIN_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_wr,
    input  logic              win_rd,
    input  logic [WIN_AW-1:0] win_addr,
    input  logic [63:0]       win_wdata,
    output logic [63:0]       win_rdata,
    output logic              lb_req_valid,
    input  logic              lb_req_ready,
    output logic              lb_req_write,
    output logic [3:0]        lb_req_size,
    output logic [31:0]       lb_req_addr,
    output logic [31:0]       lb_req_wdata,
    input  logic              lb_rsp_valid,
    input  logic              lb_rsp_err,
    input  logic [31:0]       lb_rsp_rdata
);
    logic            cmd_go;
    cmd_t            cmd;
    logic            launch;
    logic            cap_valid;
    logic            cap_read;
    logic            cap_err;
    logic [LB_W-1:0] cap_rdata;

    cwb_regfile #(.WIN_AW(WIN_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_wr    (win_wr),
        .win_rd    (win_rd),
        .win_addr  (win_addr),
        .win_wdata (win_wdata),
        .win_rdata (win_rdata),
        .cmd_go    (cmd_go),
        .cmd       (cmd),
        .launch    (launch),
        .cap_valid (cap_valid),
        .cap_read  (cap_read),
        .cap_err   (cap_err),
        .cap_rdata (cap_rdata)
    );

    cwb_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_go       (cmd_go),
        .cmd          (cmd),
        .launch       (launch),
        .cap_valid    (cap_valid),
        .cap_read     (cap_read),
        .cap_err      (cap_err),
        .cap_rdata    (cap_rdata),
        .lb_req_valid (lb_req_valid),
        .lb_req_ready (lb_req_ready),
        .lb_req_write (lb_req_write),
        .lb_req_size  (lb_req_size),
        .lb_req_addr  (lb_req_addr),
        .lb_req_wdata (lb_req_wdata),
        .lb_rsp_valid (lb_rsp_valid),
        .lb_rsp_err   (lb_rsp_err),
        .lb_rsp_rdata (lb_rsp_rdata)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !lb_req_valid); // R10
endmodule

// File: tb/cmd_window_bridge_tb.sv
module cmd_window_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_CTRL = 16'h0120;
    localparam logic [15:0] A_RST  = 16'h0128;
    localparam logic [15:0] A_STAT = 16'h0130;
    localparam logic [15:0] A_DATA = 16'h0138;
    localparam logic [63:0] DONE   = 64'h800;

    typedef struct packed {
        logic        rd;
        logic [3:0]  sz;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 4'd4, 32'h0000_0004, 32'hA1B2_C3D4, DONE},
        '{1'b0, 4'd2, 32'h0000_0010, 32'h0000_BEEF, DONE},
        '{1'b1, 4'd4, 32'h0000_0004, 32'h0,         DONE | (64'hA1B2_C3D4 << 26)},
        '{1'b1, 4'd2, 32'h0000_0010, 32'h0,         DONE | (64'h0000_BEEF << 26)},
        '{1'b1, 4'd1, 32'hE000_0000, 32'h0,         DONE | (64'hFFFF_FFFF << 26)},
        '{1'b0, 4'd4, 32'hE000_0008, 32'h1357_9BDF, DONE},
        '{1'b0, 4'd4, 32'h0000_0020, 32'hFFFF_FFFF, DONE},
        '{1'b1, 4'd8, 32'h0000_0020, 32'h0,         DONE | (64'hFFFF_FFFF << 26)}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_wr = 1'b0;
    logic        win_rd = 1'b0;
    logic [15:0] win_addr = '0;
    logic [63:0] win_wdata = '0;
    logic [63:0] win_rdata;
    logic        lb_req_valid;
    logic        lb_req_ready;
    logic        lb_req_write;
    logic [3:0]  lb_req_size;
    logic [31:0] lb_req_addr;
    logic [31:0] lb_req_wdata;
    logic        lb_rsp_valid;
    logic        lb_rsp_err;
    logic [31:0] lb_rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_window_bridge #(.WIN_AW(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .win_wr(win_wr), .win_rd(win_rd),
        .win_addr(win_addr), .win_wdata(win_wdata), .win_rdata(win_rdata),
        .lb_req_valid(lb_req_valid), .lb_req_ready(lb_req_ready),
        .lb_req_write(lb_req_write), .lb_req_size(lb_req_size),
        .lb_req_addr(lb_req_addr), .lb_req_wdata(lb_req_wdata),
        .lb_rsp_valid(lb_rsp_valid), .lb_rsp_err(lb_rsp_err),
        .lb_rsp_rdata(lb_rsp_rdata)
    );

    // simple memory behind the local bus
    logic [31:0] mem [0:15];
    logic        hold_off = 1'b0;
    logic        ready_q, pend_q, pend_err;
    logic [31:0] pend_rd;
    logic        acc_write;
    logic [3:0]  acc_size;
    logic [31:0] acc_addr, acc_wdata;
    int          acc_count = 0;

    assign lb_req_ready = ready_q;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q      <= 1'b0;
            pend_q       <= 1'b0;
            pend_err     <= 1'b0;
            pend_rd      <= '0;
            lb_rsp_valid <= 1'b0;
            lb_rsp_err   <= 1'b0;
            lb_rsp_rdata <= '0;
        end else begin
            ready_q      <= lb_req_valid && !ready_q && !hold_off;
            lb_rsp_valid <= 1'b0;
            if (lb_req_valid && ready_q) begin
                acc_count <= acc_count + 1;
                acc_write <= lb_req_write;
                acc_size  <= lb_req_size;
                acc_addr  <= lb_req_addr;
                acc_wdata <= lb_req_wdata;
                pend_q    <= 1'b1;
                pend_err  <= (lb_req_addr[31:28] == 4'hE);
                pend_rd   <= (lb_req_addr[31:28] == 4'hE) ? 32'h1234_5678
                                                          : mem[lb_req_addr[5:2]];
                if (lb_req_write && lb_req_addr[31:28] != 4'hE)
                    mem[lb_req_addr[5:2]] <= lb_req_wdata;
            end
            if (pend_q) begin
                pend_q       <= 1'b0;
                lb_rsp_valid <= 1'b1;
                lb_rsp_err   <= pend_err;
                lb_rsp_rdata <= pend_rd;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic win_write(input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        win_wr = 1'b1; win_addr = a; win_wdata = d;
        @(negedge clk);
        win_wr = 1'b0;
    endtask

    task automatic win_read(input logic [15:0] a, output logic [63:0] d);
        @(negedge clk);
        win_rd = 1'b1; win_addr = a;
        #1 d = win_rdata;
        @(negedge clk);
        win_rd = 1'b0;
    endtask

    task automatic poll(output logic [63:0] d);
        d = '0;
        for (int i = 0; i < 40 && d == '0; i++) win_read(A_STAT, d);
    endtask

    function automatic logic [63:0] mk_ctrl(input logic rd, input logic [3:0] sz,
                                            input logic [31:0] a);
        return (64'(rd) << 48) | (64'(sz) << 56) | 64'(a) | 64'hF000_0000_0000_0000;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL R4: watchdog expired, actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] rv;
        int          base;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        chk("R10 req idle", 64'(lb_req_valid), 64'h0);
        win_read(A_STAT, rv); chk("R10 status", rv, 64'h0);
        win_read(A_DATA, rv); chk("R10 data", rv, 64'h0);
        win_read(A_CTRL, rv); chk("R10 ctrl", rv, 64'h0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            base = acc_count;
            win_write(A_DATA, {VECS[v].wd, 32'h5A5A_5A5A});
            win_write(A_CTRL, mk_ctrl(VECS[v].rd, VECS[v].sz, VECS[v].addr));
            poll(rv);
            chk(VECS[v].rd ? "R6/R7 read status" : "R5 write status", rv, VECS[v].exp);
            chk("R4 one request", 64'(acc_count - base), 64'd1);
            chk("R4 addr", 64'(acc_addr), 64'(VECS[v].addr));
            chk("R4 size", 64'(acc_size), 64'(VECS[v].sz));
            chk("R4 dir", 64'(acc_write), 64'(!VECS[v].rd));
            if (!VECS[v].rd) chk("R5 wdata", 64'(acc_wdata), 64'(VECS[v].wd));
            win_read(A_STAT, rv); chk("R8 clear on read", rv, 64'h0);
        end

        // R2 data register readback, R1 aliasing through upper address bits
        win_write(A_DATA, 64'hDEAD_BEEF_0102_0304);
        win_read(A_DATA, rv);   chk("R2 data readback", rv, 64'hDEAD_BEEF_0000_0000);
        win_read(16'h0038, rv); chk("R1 alias data", rv, 64'hDEAD_BEEF_0000_0000);
        win_read(16'h0FF0, rv); chk("R1 alias status", rv, 64'h0);

        // R3 ignored writes
        base = acc_count;
        win_write(A_STAT, '1);
        win_read(A_STAT, rv);  chk("R3 status write ignored", rv, 64'h0);
        win_write(A_RST, '1);
        repeat (6) @(negedge clk);
        chk("R3 reset write no request", 64'(acc_count - base), 64'h0);
        win_read(A_DATA, rv);  chk("R3 reset write keeps data", rv, 64'hDEAD_BEEF_0000_0000);
        win_read(A_RST, rv);   chk("R3 reset reads zero", rv, 64'h0);
        win_read(A_CTRL, rv);  chk("R3 ctrl reads zero", rv, 64'h0);

        // R9 busy drop, R8 zero while busy
        hold_off = 1'b1;
        base = acc_count;
        win_write(A_DATA, {32'h1111_2222, 32'h0});
        win_write(A_CTRL, mk_ctrl(1'b0, 4'd4, 32'h0000_0008));
        repeat (3) @(negedge clk);
        chk("R4 held request", 64'(lb_req_valid), 64'h1);
        win_write(A_CTRL, mk_ctrl(1'b1, 4'd1, 32'h0000_000C));
        chk("R9 addr unchanged", 64'(lb_req_addr), 64'h8);
        chk("R9 dir unchanged", 64'(lb_req_write), 64'h1);
        win_read(A_STAT, rv); chk("R8 zero while busy", rv, 64'h0);
        hold_off = 1'b0;
        poll(rv);             chk("R5 status after stall", rv, DONE);
        repeat (10) @(negedge clk);
        chk("R9 single request", 64'(acc_count - base), 64'h1);
        chk("R5 stalled wdata", 64'(acc_wdata), 64'h1111_2222);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule